// File: doc/BRIEF.md
# I2C-Controlled Clock Fanout Gate

This block takes one reference clock and fans it out to a bank of clock outputs, eighteen by default. Each output either passes the reference clock or is held low, as set by its own enable bit. The enable bits sit in three byte-wide control registers. A write-only two-wire serial slave, running in the standard-mode speed class, loads those registers.

A host addresses the block with its 7-bit slave address and a write bit. It then sends up to three data bytes, and these land in registers 0, 1 and 2 in that order. There is no register pointer and no read-back. A stop condition or a repeated start always returns the load position to register 0.

The serial lines are oversampled by a system clock that runs at least eight times the bus rate. Enable changes reach the clock outputs only on a falling edge of the reference clock, so a gated output never produces a shortened pulse. A global output-enable input is passed to the pad ring as a drive enable. When that input is low, every clock output pad is in high impedance. When it is high, the pads drive normally.

Top module: `clk_fanout_gate`

## Requirements
- R1: After reset every enable bit is 1, so every clock output follows the reference clock: high while it is high, low while it is low.
- R2: Register 0 bit k gates output k, register 1 bit k gates output 8+k, and register 2 bits 0 and 1 gate outputs 16 and 17. A 1 passes the clock. A 0 holds that output low in both clock phases.
- R3: After an accepted address, the first, second and third data bytes are stored in registers 0, 1 and 2 in that order.
- R4: Data bytes after the third are acknowledged and change no register.
- R5: A stop or a repeated start returns the load position to register 0.
- R6: The block acknowledges only its own 7-bit address (parameter, default 0x69) followed by a write bit of 0. For a read bit or another address it sends no acknowledge, and the data bytes that follow change no register.
- R7: For each accepted address byte and data byte, the block pulls SDA low through the ninth SCL clock.
- R8: A data byte updates its register at the end of that byte, before any stop arrives. An output's level never changes while the reference clock is high.
- R9: pad_drive_en equals oe_in. When it is 0, all clock output pads are in high impedance.
- R10: Bits 2 to 7 of register 2 have no effect on any output.
- R11: The block never pulls SDA low while the bus is idle, and it only starts pulling SDA while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | Open-drain drive: 1 pulls SDA low |
| ref_clk | input | 1 | Reference clock to be fanned out |
| oe_in | input | 1 | Global output enable; the pad defaults it high |
| fan_out | output | NUM_OUT | Gated clock outputs |
| pad_drive_en | output | 1 | Drive enable for the clock output pads; 0 means high impedance |

## Verification
The bench walks a single cleared enable bit across every output and checks the outputs in both clock phases. A wrong bit mapping, or gating that floats instead of holding low, shows up as a mismatched mask. It also sends partial writes, over-long writes and repeated starts. A load position that is not reset, or one that wraps instead of saturating, would then corrupt register 0 or register 1. Foreign addresses and read requests are checked for the absence of an acknowledge and for unchanged outputs. A register update that waits for the stop condition instead of the end of its byte is caught by a check taken in the middle of a transaction.

// File: rtl/cfan_pkg.sv
package cfan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } slv_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  // bus idles high, so every stage resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import cfan_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NUM_REGS   = 3,
  parameter int         IDX_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              idle
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  slv_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  ptr;
  logic              addr_ok;
  logic              byte_done;
  logic              shifting;

  assign addr_ok   = (shreg[BYTE_W-1:1] == SLAVE_ADDR) && !shreg[0];
  assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
  assign shifting  = scl_rise && (bit_cnt < CNT_W'(BYTE_W));
  assign idle      = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        ptr      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        ptr      <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (shifting) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_ok) begin
                  state    <= ST_AACK;
                  sda_pull <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                state    <= ST_DACK;
                sda_pull <= 1'b1;
                // the load position saturates at NUM_REGS: surplus bytes are dropped
                if (ptr < IDX_W'(NUM_REGS)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                end
              end
            end
          end
          ST_AACK, ST_DACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/enable_bank.sv
module enable_bank
  import cfan_pkg::*;
#(
  parameter int NUM_OUT  = 18,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NUM_OUT-1:0] en_vec
);
  // only bits that reach an output are stored
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_bit
    localparam int RI = o / BYTE_W;
    localparam int BI = o % BYTE_W;
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= 1'b1;
      else if (wr_en && (wr_idx == IDX_W'(RI)))
        q <= wr_data[BI];
    end
    assign en_vec[o] = q;
  end
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter int SYNC = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en_in,
  output logic gclk
);
  logic [SYNC-1:0] en_ff;

  // enable only moves while ref_clk is low, so the AND never clips a pulse
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n)
      en_ff <= '1;
    else
      en_ff <= {en_ff[SYNC-2:0], en_in};
  end

  assign gclk = ref_clk & en_ff[SYNC-1];
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import cfan_pkg::*;
#(
  parameter int         NUM_OUT     = 18,
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               sys_clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull_low,
  input  logic               ref_clk,
  input  logic               oe_in,
  output logic [NUM_OUT-1:0] fan_out,
  output logic               pad_drive_en
);
  localparam int NUM_REGS = (NUM_OUT + BYTE_W - 1) / BYTE_W;
  localparam int IDX_W    = $clog2(NUM_REGS + 1);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic              slave_idle;
  logic [NUM_OUT-1:0] en_vec;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (sys_clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_wr_slave #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .NUM_REGS   (NUM_REGS),
    .IDX_W      (IDX_W)
  ) u_slave (
    .clk       (sys_clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_low),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .idle      (slave_idle)
  );

  enable_bank #(
    .NUM_OUT (NUM_OUT),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk     (sys_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .en_vec  (en_vec)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_gate
    clk_gate_cell #(.SYNC(SYNC_STAGES)) u_cell (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .en_in   (en_vec[o]),
      .gclk    (fan_out[o])
    );
  end

  assign pad_drive_en = oe_in;
endmodule

// File: rtl/cfan_checker.sv
module cfan_checker #(
  parameter int NUM_OUT  = 18,
  parameter int NUM_REGS = 3,
  parameter int IDX_W    = 2
) (
  input logic               sys_clk,
  input logic               rst_n,
  input logic               ref_clk,
  input logic [NUM_OUT-1:0] fan_out,
  input logic               sda_pull_low,
  input logic               scl_s,
  input logic               slave_idle,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx
);
  // R8: no output edge while the reference clock stays high
  a_r8_no_runt: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (ref_clk && $past(ref_clk)) |-> $stable(fan_out));

  // R2: gated outputs are low whenever the reference clock is low
  a_r2_low_phase: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !ref_clk |-> (fan_out == '0));

  // R11: acknowledge drive begins only with SCL low
  a_r11_pull_scl_low: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !scl_s);

  // R11: idle bus is never pulled
  a_r11_idle_quiet: assert property (@(posedge sys_clk) disable iff (!rst_n)
    slave_idle |-> !sda_pull_low);

  // R4: stores never target a register beyond the bank
  a_r4_idx_range: assert property (@(posedge sys_clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));
endmodule

bind clk_fanout_gate cfan_checker #(
  .NUM_OUT  (NUM_OUT),
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W)
) u_chk (
  .sys_clk      (sys_clk),
  .rst_n        (rst_n),
  .ref_clk      (ref_clk),
  .fan_out      (fan_out),
  .sda_pull_low (sda_pull_low),
  .scl_s        (scl_s),
  .slave_idle   (slave_idle),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx)
);

// File: tb/tb_clk_fanout_gate.sv
`timescale 1ns/100ps
module tb_clk_fanout_gate;
  localparam int NOUT = 18;

  logic sys_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic tb_scl  = 1'b1;
  logic tb_sda  = 1'b1;
  logic oe_in   = 1'b1;
  logic sda_pull_low;
  logic pad_drive_en;
  logic [NOUT-1:0] fan_out;
  logic sda_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_reg [3];
  logic [7:0] pl [5];

  always #2.5 sys_clk = ~sys_clk;
  always #17  ref_clk = ~ref_clk;

  assign sda_line = tb_sda & ~sda_pull_low;

  clk_fanout_gate dut (
    .sys_clk      (sys_clk),
    .rst_n        (rst_n),
    .scl_in       (tb_scl),
    .sda_in       (sda_line),
    .sda_pull_low (sda_pull_low),
    .ref_clk      (ref_clk),
    .oe_in        (oe_in),
    .fan_out      (fan_out),
    .pad_drive_en (pad_drive_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mask();
    return 32'({exp_reg[2][1:0], exp_reg[1], exp_reg[0]});
  endfunction

  task automatic q();
    repeat (10) @(negedge sys_clk);
  endtask

  task automatic bus_start();
    tb_sda = 1'b1; q();
    tb_scl = 1'b1; q();
    tb_sda = 1'b0; q();
    tb_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    tb_sda = 1'b0; q();
    tb_scl = 1'b1; q();
    tb_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tb_sda = b[i]; q();
      tb_scl = 1'b1; q();
      tb_scl = 1'b0; q();
    end
    tb_sda = 1'b1; q();
    tb_scl = 1'b1; q();
    ack = ~sda_line;
    tb_scl = 1'b0; q();
  endtask

  // address byte then n payload bytes; returns the number of acknowledges
  task automatic xfer(input logic [7:0] ab, input int n, input bit stop, output int acks);
    bit a;
    acks = 0;
    bus_start();
    send_byte(ab, a);
    acks += int'(a);
    for (int k = 0; k < n; k++) begin
      send_byte(pl[k], a);
      acks += int'(a);
    end
    if (stop) bus_stop();
  endtask

  task automatic check_outputs(input string tag);
    repeat (4) @(negedge ref_clk);
    @(posedge ref_clk); #4;
    check({tag, " high phase"}, 32'(fan_out), exp_mask());
    @(negedge ref_clk); #4;
    check({tag, " low phase"}, 32'(fan_out), 32'd0);
  endtask

  initial begin
    int acks;
    for (int k = 0; k < 3; k++) exp_reg[k] = 8'hFF;
    repeat (5) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge sys_clk);

    // R1 reset state
    check_outputs("R1 reset enables");
    check("R11 idle release", 32'(sda_pull_low), 32'd0);
    check("R9 drive enable high", 32'(pad_drive_en), 32'd1);

    // R2 walking zero over every output, full three-byte writes
    for (int o = 0; o < NOUT; o++) begin
      logic [23:0] v;
      v = ~(24'd1 << o);
      pl[0] = v[7:0]; pl[1] = v[15:8]; pl[2] = v[23:16];
      xfer(8'hD2, 3, 1'b1, acks);
      check("R7 acks on full write", 32'(acks), 32'd4);
      for (int k = 0; k < 3; k++) exp_reg[k] = pl[k];
      check_outputs("R2 R3 walking zero");
    end

    // R2 all disabled
    pl[0] = 8'h00; pl[1] = 8'h00; pl[2] = 8'h00;
    xfer(8'hD2, 3, 1'b1, acks);
    for (int k = 0; k < 3; k++) exp_reg[k] = pl[k];
    check_outputs("R2 all held low");

    // R10 upper bits of register 2 have no effect
    pl[0] = 8'hFF; pl[1] = 8'hFF; pl[2] = 8'hFC;
    xfer(8'hD2, 3, 1'b1, acks);
    for (int k = 0; k < 3; k++) exp_reg[k] = pl[k];
    check_outputs("R10 unused bits ignored");

    // R8 single byte takes effect before any stop
    pl[0] = 8'h5A;
    xfer(8'hD2, 1, 1'b0, acks);
    exp_reg[0] = 8'h5A;
    check_outputs("R8 byte commits mid transaction");
    bus_stop();

    // R5 after stop the next byte lands in register 0 again
    pl[0] = 8'h3C;
    xfer(8'hD2, 1, 1'b1, acks);
    exp_reg[0] = 8'h3C;
    check_outputs("R5 R3 pointer reset by stop");

    // R4 surplus bytes acknowledged and dropped
    pl[0] = 8'hA1; pl[1] = 8'hB2; pl[2] = 8'hC3; pl[3] = 8'h00; pl[4] = 8'h00;
    xfer(8'hD2, 5, 1'b1, acks);
    check("R4 surplus bytes acked", 32'(acks), 32'd6);
    for (int k = 0; k < 3; k++) exp_reg[k] = pl[k];
    check_outputs("R4 surplus bytes dropped");

    // R5 repeated start resets the load position
    pl[0] = 8'h11;
    xfer(8'hD2, 1, 1'b0, acks);
    pl[0] = 8'h22;
    xfer(8'hD2, 1, 1'b1, acks);
    exp_reg[0] = 8'h22;
    check_outputs("R5 repeated start");

    // R6 foreign address
    pl[0] = 8'h00; pl[1] = 8'h00; pl[2] = 8'h00;
    xfer(8'h54, 3, 1'b1, acks);
    check("R6 foreign address not acked", 32'(acks), 32'd0);
    check_outputs("R6 foreign address no effect");

    // R6 read request
    xfer(8'hD3, 3, 1'b1, acks);
    check("R6 read request not acked", 32'(acks), 32'd0);
    check_outputs("R6 read request no effect");
    check("R11 released after stop", 32'(sda_pull_low), 32'd0);

    // R9 global output enable
    oe_in = 1'b0; #3;
    check("R9 drive enable low", 32'(pad_drive_en), 32'd0);
    oe_in = 1'b1; #3;
    check("R9 drive enable restored", 32'(pad_drive_en), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge sys_clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule